// File: doc/BRIEF.md
# Indexed Video Register and Palette Port

This block is a byte-wide register file addressed through a small window of host I/O ports, in the style of a classic PC display adapter. A sequencer index port selects one of a few internal sequencer registers. A companion data port then reads or writes the register it selected. One bit of the sequencer mode register blanks the video output.

The palette side takes a byte stream, not plain addressed writes. The host writes a starting entry number to the palette index port. It then pushes colour bytes into the palette data port as red, green, blue triples. An internal component counter tracks which byte comes next. After each blue byte the entry number steps forward on its own, so a single index write can load any run of colours, and the run wraps past the last entry. A pixel-side port looks the table up every cycle and returns the packed colour one cycle later, or black while video is blanked.

Top module: `vidRegPort`

## Requirements
- R1: After reset, every sequencer register, the sequencer index, the palette entry index, every palette entry and the pixel colour are zero, the component counter expects red, and `videoBlank` is 0.
- R2: A write to port offset 0x4 loads the 8-bit sequencer index. Reading offset 0x4 returns it.
- R3: Offset 0x5 reads and writes the sequencer register selected by the current index, for indices 0 to SEQ_REGS-1 (default 5). At any other index a read returns 0 and a write changes no register.
- R4: Bit 5 of sequencer register 1 is the blank control. `videoBlank` follows that bit with one cycle of register delay after the data write: 1 when the bit is set, 0 when it is clear. Other bits of the register have no effect on it.
- R5: `pixColor` is the palette entry at `pixIndex`, registered one cycle, packed as red in bits 23:16, green in 15:8 and blue in 7:0.
- R6: A write to offset 0x8 loads the palette entry index and returns the component counter to red, dropping any partly sent colour. Reading offset 0x8 returns the entry index.
- R7: Writes to offset 0x9 are taken as red, then green, then blue. The addressed entry changes only on the blue write, all three components at once, and the entry index then advances by one.
- R8: The palette entry index wraps from 255 to 0 after a blue write.
- R9: While `videoBlank` is 1, `pixColor` is forced to zero on the next cycle, whatever the palette holds.
- R10: Reads of any offset other than 0x4, 0x5 and 0x8 return 0. Writes to such offsets change no state. Reads never change state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Port offset within the 16-port window |
| hostWr | input | 1 | Write strobe, one byte per cycle |
| hostWrData | input | 8 | Write data byte |
| hostRdData | output | 8 | Read data for `hostAddr`, combinational |
| pixIndex | input | 8 | Palette entry looked up on the pixel side |
| pixColor | output | 24 | Looked-up colour {red, green, blue}, one cycle later |
| videoBlank | output | 1 | Registered video blank flag |

## Verification
A component counter that drifts by one byte makes every colour loaded after it land rotated. The first blue commit shows a wrong `pixColor` one cycle later, and the index readback on offset 0x8 drifts at the same point. A wrong entry index shows on offset 0x8 in the same cycle it is written. A half-committed colour would appear on `pixColor` one cycle after its red or green byte, while the bench is watching that entry. A stale blank flag shows as a non-zero pixel in the second cycle after the mode write.

// File: rtl/vrp_pkg.sv
package vrp_pkg;

  // Port offsets inside the host window; decoding depends on these values.
  localparam logic [3:0] OFF_SEQ_IDX  = 4'h4;
  localparam logic [3:0] OFF_SEQ_DATA = 4'h5;
  localparam logic [3:0] OFF_PAL_IDX  = 4'h8;
  localparam logic [3:0] OFF_PAL_DATA = 4'h9;

  // Sequencer register that carries the blank control, and the bit used.
  localparam int MODE_IDX  = 1;
  localparam int BLANK_BIT = 5;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } compE;

  typedef enum logic [1:0] {
    RD_NONE     = 2'd0,
    RD_SEQ_IDX  = 2'd1,
    RD_SEQ_DATA = 2'd2,
    RD_PAL_IDX  = 2'd3
  } rdSelE;

  typedef struct packed {
    logic  seqIdxWr;
    logic  seqDataWr;
    logic  palIdxWr;
    logic  palRedWr;
    logic  palGreenWr;
    logic  palBlueWr;
    rdSelE rdSel;
  } strobeT;

endpackage

// File: rtl/vrp_ctrl.sv
module vrp_ctrl
  import vrp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  output strobeT            st
);

  compE comp;
  logic isSeqIdx, isSeqData, isPalIdx, isPalData;

  assign isSeqIdx  = (hostAddr == ADDR_W'(OFF_SEQ_IDX));
  assign isSeqData = (hostAddr == ADDR_W'(OFF_SEQ_DATA));
  assign isPalIdx  = (hostAddr == ADDR_W'(OFF_PAL_IDX));
  assign isPalData = (hostAddr == ADDR_W'(OFF_PAL_DATA));

  always_comb begin
    st            = '0;
    st.rdSel      = RD_NONE;
    st.seqIdxWr   = hostWr && isSeqIdx;
    st.seqDataWr  = hostWr && isSeqData;
    st.palIdxWr   = hostWr && isPalIdx;
    st.palRedWr   = hostWr && isPalData && (comp == COMP_RED);
    st.palGreenWr = hostWr && isPalData && (comp == COMP_GREEN);
    st.palBlueWr  = hostWr && isPalData && (comp == COMP_BLUE);
    if (isSeqIdx)       st.rdSel = RD_SEQ_IDX;
    else if (isSeqData) st.rdSel = RD_SEQ_DATA;
    else if (isPalIdx)  st.rdSel = RD_PAL_IDX;
  end

  // Component counter: red -> green -> blue -> red, restarted by an index write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      comp <= COMP_RED;
    end else if (st.palIdxWr) begin
      comp <= COMP_RED;
    end else if (st.palRedWr) begin
      comp <= COMP_GREEN;
    end else if (st.palGreenWr) begin
      comp <= COMP_BLUE;
    end else if (st.palBlueWr) begin
      comp <= COMP_RED;
    end
  end

  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.seqIdxWr, st.seqDataWr, st.palIdxWr,
              st.palRedWr, st.palGreenWr, st.palBlueWr}))
    else $error("more than one write strobe");

  p_idx_restarts_comp_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.palIdxWr |=> comp == COMP_RED)
    else $error("index write did not restart component counter");

  p_red_follows_blue_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.palBlueWr |=> comp == COMP_RED)
    else $error("counter not back to red after blue");

  p_green_follows_red_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.palRedWr |=> comp == COMP_GREEN)
    else $error("counter not at green after red");

endmodule

// File: rtl/vrp_datapath.sv
module vrp_datapath
  import vrp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PAL_DEPTH = 256,
  parameter int SEQ_REGS  = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobeT                        st,
  input  logic [DATA_W-1:0]             hostWrData,
  output logic [DATA_W-1:0]             hostRdData,
  input  logic [$clog2(PAL_DEPTH)-1:0]  pixIndex,
  output logic [3*DATA_W-1:0]           pixColor,
  output logic                          videoBlank
);

  localparam int PAL_IW = $clog2(PAL_DEPTH);
  localparam int COLOR_W = 3 * DATA_W;
  localparam int SEQ_IW = (SEQ_REGS > 1) ? $clog2(SEQ_REGS) : 1;
  localparam logic [DATA_W-1:0] SEQ_LIM = DATA_W'(SEQ_REGS);

  logic [DATA_W-1:0]  seqIdx;
  logic [DATA_W-1:0]  seqRegs [SEQ_REGS];
  logic [PAL_IW-1:0]  palWrIdx;
  logic [DATA_W-1:0]  redStage, greenStage;
  logic [COLOR_W-1:0] palMem [PAL_DEPTH];
  logic               seqHit;

  assign seqHit = (seqIdx < SEQ_LIM);

  // Sequencer index and register bank.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqIdx <= '0;
    end else if (st.seqIdxWr) begin
      seqIdx <= hostWrData;
    end
  end

  for (genvar g = 0; g < SEQ_REGS; g++) begin : gSeq
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        seqRegs[g] <= '0;
      end else if (st.seqDataWr && seqIdx == DATA_W'(g)) begin
        seqRegs[g] <= hostWrData;
      end
    end
  end

  // Palette entry index and component staging.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      palWrIdx   <= '0;
      redStage   <= '0;
      greenStage <= '0;
    end else begin
      if (st.palIdxWr)   palWrIdx   <= hostWrData[PAL_IW-1:0];
      if (st.palRedWr)   redStage   <= hostWrData;
      if (st.palGreenWr) greenStage <= hostWrData;
      if (st.palBlueWr)  palWrIdx   <= palWrIdx + PAL_IW'(1);
    end
  end

  // Colour table: one whole entry is committed on the blue byte.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAL_DEPTH; i++) palMem[i] <= '0;
    end else if (st.palBlueWr) begin
      palMem[palWrIdx] <= {redStage, greenStage, hostWrData};
    end
  end

  // Blank flag and pixel lookup.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      videoBlank <= 1'b0;
      pixColor   <= '0;
    end else begin
      videoBlank <= seqRegs[MODE_IDX][BLANK_BIT];
      pixColor   <= videoBlank ? '0 : palMem[pixIndex];
    end
  end

  // Host read mux.
  always_comb begin
    hostRdData = '0;
    case (st.rdSel)
      RD_SEQ_IDX:  hostRdData = seqIdx;
      RD_SEQ_DATA: hostRdData = seqHit ? seqRegs[seqIdx[SEQ_IW-1:0]] : '0;
      RD_PAL_IDX:  hostRdData = DATA_W'(palWrIdx);
      default:     hostRdData = '0;
    endcase
  end

  p_blank_tracks_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    videoBlank == $past(seqRegs[MODE_IDX][BLANK_BIT]))
    else $error("blank flag does not follow mode bit");

  p_blank_black_r9: assert property (@(posedge clk) disable iff (!rstN)
    videoBlank |=> pixColor == '0)
    else $error("pixel not black while blanked");

  p_idx_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.palBlueWr |=> palWrIdx == $past(palWrIdx) + PAL_IW'(1))
    else $error("entry index did not advance after blue");

  p_idx_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.palIdxWr |=> palWrIdx == $past(hostWrData[PAL_IW-1:0]))
    else $error("entry index not loaded");

  p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!st.palIdxWr && !st.palBlueWr) |=> $stable(palWrIdx))
    else $error("entry index moved without cause");

endmodule

// File: rtl/vidRegPort.sv
module vidRegPort
  import vrp_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PAL_DEPTH = 256,
  parameter int SEQ_REGS  = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic                         hostWr,
  input  logic [DATA_W-1:0]            hostWrData,
  output logic [DATA_W-1:0]            hostRdData,
  input  logic [$clog2(PAL_DEPTH)-1:0] pixIndex,
  output logic [3*DATA_W-1:0]          pixColor,
  output logic                         videoBlank
);

  strobeT st;

  vrp_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostAddr (hostAddr),
    .hostWr   (hostWr),
    .st       (st)
  );

  vrp_datapath #(
    .DATA_W    (DATA_W),
    .PAL_DEPTH (PAL_DEPTH),
    .SEQ_REGS  (SEQ_REGS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .pixIndex   (pixIndex),
    .pixColor   (pixColor),
    .videoBlank (videoBlank)
  );

endmodule

// File: tb/vidRegPort_test.sv
`timescale 1ns/1ps
module vidRegPort_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostAddr = 4'h0;
  logic        hostWr = 1'b0;
  logic [7:0]  hostWrData = 8'h00;
  logic [7:0]  hostRdData;
  logic [7:0]  pixIndex = 8'h00;
  logic [23:0] pixColor;
  logic        videoBlank;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit checking = 1'b0;
  string curReq = "R1";

  // Reference model state.
  logic [7:0]  mSeq [5];
  logic [7:0]  mSeqIdx;
  logic [23:0] mPal [256];
  logic [7:0]  mPalIdx;
  int          mComp;
  logic [7:0]  mRed, mGreen;
  logic        mBlank;
  logic [23:0] mPix;

  always #2 clk = ~clk;

  vidRegPort uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .pixIndex(pixIndex), .pixColor(pixColor), .videoBlank(videoBlank)
  );

  function automatic logic [7:0] expRead(input logic [3:0] a);
    case (a)
      4'h4: return mSeqIdx;
      4'h5: return (mSeqIdx < 8'd5) ? mSeq[mSeqIdx[2:0]] : 8'h00;
      4'h8: return mPalIdx;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      for (int i = 0; i < 5; i++) mSeq[i] = 8'h00;
      for (int i = 0; i < 256; i++) mPal[i] = 24'h0;
      mSeqIdx = 8'h00; mPalIdx = 8'h00; mComp = 0;
      mRed = 8'h00; mGreen = 8'h00; mBlank = 1'b0; mPix = 24'h0;
    end else begin
      logic [23:0] nPix;
      logic        nBlank;
      nPix   = mBlank ? 24'h0 : mPal[pixIndex];
      nBlank = mSeq[1][5];
      if (hostWr) begin
        case (hostAddr)
          4'h4: mSeqIdx = hostWrData;
          4'h5: if (mSeqIdx < 8'd5) mSeq[mSeqIdx[2:0]] = hostWrData;
          4'h8: begin mPalIdx = hostWrData; mComp = 0; end
          4'h9: begin
            if (mComp == 0) begin mRed = hostWrData; mComp = 1; end
            else if (mComp == 1) begin mGreen = hostWrData; mComp = 2; end
            else begin
              mPal[mPalIdx] = {mRed, mGreen, hostWrData};
              mPalIdx = mPalIdx + 8'd1;
              mComp = 0;
            end
          end
          default: ;
        endcase
      end
      mPix = nPix; mBlank = nBlank;
    end
    #1;
    if (checking) begin
      vectors++;
      if (hostRdData !== expRead(hostAddr)) begin
        miscompares++;
        $display("FAIL %s: read @%h act %h exp %h", curReq, hostAddr, hostRdData, expRead(hostAddr));
      end
      if (videoBlank !== mBlank) begin
        miscompares++;
        $display("FAIL %s: videoBlank act %b exp %b", curReq, videoBlank, mBlank);
      end
      if (pixColor !== mPix) begin
        miscompares++;
        $display("FAIL %s: pixColor act %h exp %h", curReq, pixColor, mPix);
      end
    end
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWr = 1'b1; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic look(input logic [3:0] a, input int n);
    @(negedge clk);
    hostAddr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic colour(input logic [23:0] c);
    wr(4'h9, c[23:16]); wr(4'h9, c[15:8]); wr(4'h9, c[7:0]);
  endtask

  initial begin
    checking = 1'b1;
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    look(4'h5, 2); look(4'h8, 2);

    curReq = "R2";
    wr(4'h4, 8'h03); look(4'h4, 2);
    wr(4'h4, 8'hC7); look(4'h4, 2);

    curReq = "R3";
    for (int i = 0; i < 5; i++) begin
      wr(4'h4, 8'(i)); wr(4'h5, 8'(8'h11 * (i + 3)));
      look(4'h5, 1);
    end
    wr(4'h4, 8'h02); look(4'h5, 1);
    wr(4'h4, 8'h07); wr(4'h5, 8'h3C); look(4'h5, 2);
    wr(4'h4, 8'hFF); wr(4'h5, 8'h55); look(4'h5, 1);
    for (int i = 0; i < 5; i++) begin wr(4'h4, 8'(i)); look(4'h5, 1); end

    curReq = "R5";
    wr(4'h4, 8'h01); wr(4'h5, 8'h00);
    wr(4'h8, 8'h0A);
    pixIndex = 8'h0A;
    colour(24'h123456);
    colour(24'hA1B2C3);
    look(4'h8, 2);

    curReq = "R7";
    pixIndex = 8'h40;
    wr(4'h8, 8'h40);
    wr(4'h9, 8'hDE); look(4'h8, 2);
    wr(4'h9, 8'hAD); look(4'h8, 2);
    wr(4'h9, 8'hBE); look(4'h8, 2);
    for (int i = 0; i < 4; i++) colour(24'(32'h010203 * (i + 5)));
    for (int i = 8'h40; i < 8'h46; i++) begin pixIndex = 8'(i); look(4'h8, 1); end

    curReq = "R6";
    pixIndex = 8'h14;
    wr(4'h8, 8'h14); wr(4'h9, 8'h77); wr(4'h9, 8'h88);
    wr(4'h8, 8'h1E); colour(24'hCAFE01);
    look(4'h8, 2);
    pixIndex = 8'h1E; look(4'h8, 2);

    curReq = "R8";
    pixIndex = 8'hFF;
    wr(4'h8, 8'hFF); colour(24'h0F0E0D); look(4'h8, 2);
    colour(24'h707172); pixIndex = 8'h00; look(4'h8, 2);

    curReq = "R4";
    wr(4'h4, 8'h01); wr(4'h5, 8'h20); look(4'h5, 3);
    wr(4'h5, 8'hDF); look(4'h5, 3);
    wr(4'h5, 8'hFF); look(4'h5, 3);

    curReq = "R9";
    pixIndex = 8'h0A; look(4'h5, 2);
    wr(4'h8, 8'h0A); colour(24'hFFFFFF); look(4'h8, 2);
    wr(4'h4, 8'h01); wr(4'h5, 8'h00); look(4'h5, 3);

    curReq = "R10";
    wr(4'h0, 8'hAA); wr(4'h6, 8'h20); wr(4'hF, 8'h5A); wr(4'hC, 8'h11);
    look(4'h0, 1); look(4'h1, 1); look(4'h9, 1); look(4'h3, 1); look(4'hF, 1);
    look(4'h4, 1); look(4'h5, 1); look(4'h8, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule